// File: doc/BRIEF.md
# Segment Register with Hidden Descriptor Cache

This block models a single segment register as a processor core sees it. Software can see and read back a 16-bit selector. Every access, however, is translated through a hidden descriptor cache that sits behind the selector. The cache holds a linear base, a byte limit, read, write and execute permissions, and two default-size flags: one for address size and one for operand size. Address generation reads only the cache and never the selector.

How a selector load affects the cache depends on the mode flag at the moment of the load. In protected mode, a load copies a descriptor that has already been fetched and is presented on the load port, and it replaces every cached field. In real mode, a load only recomputes the base as the selector times sixteen, and the other cached fields keep their values. Changing the mode flag on its own changes nothing in the cache. As a result, a wide segment set up in protected mode stays wide after the core drops back to real mode. The address path is combinational from the cache. In the same cycle it returns the linear address, a limit-violation flag and a permission-fault flag for each offset request.

Top module: `seg_unit`

## Requirements
- R1: After reset the cache holds base 0, limit 0x0000FFFF, read, write and execute all granted, and 16-bit address and operand sizes. The visible selector reads 0.
- R2: The linear address is the cached base plus the effective offset, truncated to 32 bits. It does not depend on the visible selector value.
- R3: A selector load in real mode (`prot_mode`=0) sets the cached base to the selector shifted left by four bits. For example, 0xF000 gives 0x000F0000.
- R4: A real-mode load leaves the cached limit, permissions and both size flags unchanged, and ignores the descriptor inputs.
- R5: A load in protected mode (`prot_mode`=1) replaces every cached field with the descriptor presented on the `ld_*` inputs.
- R6: Changing `prot_mode` without a load alters no cached field.
- R7: `lim_fault` is 1 exactly when the effective offset plus `acc_len` exceeds the cached limit. `acc_len` holds the access size in bytes minus one (0 to 3 for 1 to 4 bytes).
- R8: When the cached address size is 16 bits (`cur_asz32`=0), only the low 16 bits of `acc_off` form the effective offset. When it is 32 bits, all of `acc_off` is used.
- R9: `perm_fault` is 1 in the same cycle as the address exactly when the requested kind lacks its cached permission. `acc_type` encodes the kind as 0 read, 1 write, 2 execute, 3 read.
- R10: `sel_q` always returns the last selector loaded, in either mode.
- R11: `cur_asz32` and `cur_osz32` show the cached address and operand size flags (1 means 32-bit).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prot_mode | input | 1 | 1 = protected mode, 0 = real mode |
| ld_en | input | 1 | Selector load strobe |
| ld_sel | input | 16 | Selector value to load |
| ld_base | input | 32 | Descriptor base (protected loads) |
| ld_limit | input | 32 | Descriptor byte limit (protected loads) |
| ld_rd | input | 1 | Descriptor read permission |
| ld_wr | input | 1 | Descriptor write permission |
| ld_ex | input | 1 | Descriptor execute permission |
| ld_asz32 | input | 1 | Descriptor 32-bit address size |
| ld_osz32 | input | 1 | Descriptor 32-bit operand size |
| acc_off | input | 32 | Access offset |
| acc_len | input | 2 | Access bytes minus one |
| acc_type | input | 2 | Access kind: 0 read, 1 write, 2 execute, 3 read |
| sel_q | output | 16 | Visible selector |
| lin_addr | output | 32 | Linear address |
| lim_fault | output | 1 | Limit violation |
| perm_fault | output | 1 | Permission fault |
| cur_asz32 | output | 1 | Cached address size flag |
| cur_osz32 | output | 1 | Cached operand size flag |

## Verification
The bench sweeps 32 real-mode selectors and feeds junk on the descriptor inputs during each one. This separates a base rebuilt from the selector from a base copied off the load port, and it catches any clobbering of the limit and size fields. It then loads a 4-GiB protected descriptor, switches to real mode, reloads the selector and probes offsets above 64 KiB. Only a cache that survives both the mode switch and the real-mode reload gives the expected addresses. Offsets around a small limit are swept with every access length, which locates off-by-one errors in the limit compare. All eight permission combinations are crossed with all four access kinds to check the fault select. Masked 16-bit offsets and a base near 2^32 exercise truncation and wraparound.

// File: rtl/seg_pkg.sv
package seg_pkg;
  localparam int unsigned ADDR_W  = 32;
  localparam int unsigned SEL_W   = 16;
  localparam int unsigned SHIFT   = 4;
  localparam int unsigned NARROW_W = 16;
  localparam int unsigned LEN_W   = 2;

  typedef struct packed {
    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] limit;
    logic              rd;
    logic              wr;
    logic              ex;
    logic              asz32;
    logic              osz32;
  } seg_desc_t;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2,
    ACC_READ2 = 2'd3
  } acc_kind_e;

  localparam seg_desc_t SEG_RESET = '{
    base:  '0,
    limit: ADDR_W'(32'h0000_FFFF),
    rd:    1'b1,
    wr:    1'b1,
    ex:    1'b1,
    asz32: 1'b0,
    osz32: 1'b0
  };
endpackage

// File: rtl/seg_rst_sync.sv
module seg_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/seg_sel_reg.sv
module seg_sel_reg #(
  parameter int unsigned SEL_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_en,
  input  logic [SEL_W-1:0] ld_sel,
  output logic [SEL_W-1:0] sel_q
);
  logic [SEL_W-1:0] sel_d;

  always_comb begin
    sel_d = sel_q;
    if (ld_en) sel_d = ld_sel;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sel_q <= '0;
    else if (ld_en) sel_q <= sel_d;
  end
endmodule

// File: rtl/seg_cache_reg.sv
module seg_cache_reg
  import seg_pkg::*;
#(
  parameter int unsigned SEL_W = seg_pkg::SEL_W,
  parameter int unsigned SHIFT = seg_pkg::SHIFT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             prot_mode,
  input  logic             ld_en,
  input  logic [SEL_W-1:0] ld_sel,
  input  seg_desc_t        ld_desc,
  output seg_desc_t        cache_q
);
  localparam int unsigned PAD = ADDR_W - SEL_W - SHIFT;

  seg_desc_t        cache_d;
  logic [ADDR_W-1:0] real_base;

  // Real-mode base: selector scaled by 2^SHIFT, zero-extended.
  assign real_base = {{PAD{1'b0}}, ld_sel, {SHIFT{1'b0}}};

  always_comb begin
    cache_d = cache_q;
    if (ld_en) begin
      if (prot_mode) cache_d = ld_desc;
      else           cache_d.base = real_base;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cache_q <= SEG_RESET;
    else if (ld_en) cache_q <= cache_d;
  end
endmodule

// File: rtl/seg_agu.sv
module seg_agu
  import seg_pkg::*;
#(
  parameter int unsigned NARROW = seg_pkg::NARROW_W
) (
  input  seg_desc_t         cache_q,
  input  logic [ADDR_W-1:0] acc_off,
  input  logic [LEN_W-1:0]  acc_len,
  input  logic [1:0]        acc_type,
  output logic [ADDR_W-1:0] lin_addr,
  output logic              lim_fault,
  output logic              perm_fault
);
  logic [ADDR_W-1:0] off_eff;
  logic [ADDR_W:0]   last_byte;
  acc_kind_e         kind;

  generate
    if (NARROW < ADDR_W) begin : g_mask
      always_comb begin
        off_eff = acc_off;
        if (!cache_q.asz32) off_eff = {{(ADDR_W-NARROW){1'b0}}, acc_off[NARROW-1:0]};
      end
    end else begin : g_pass
      assign off_eff = acc_off;
    end
  endgenerate

  assign lin_addr  = cache_q.base + off_eff;
  assign last_byte = {1'b0, off_eff} + {{(ADDR_W+1-LEN_W){1'b0}}, acc_len};
  assign lim_fault = last_byte > {1'b0, cache_q.limit};

  assign kind = acc_kind_e'(acc_type);

  always_comb begin
    unique case (kind)
      ACC_WRITE: perm_fault = !cache_q.wr;
      ACC_EXEC:  perm_fault = !cache_q.ex;
      default:   perm_fault = !cache_q.rd;
    endcase
  end
endmodule

// File: rtl/seg_unit.sv
module seg_unit
  import seg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prot_mode,
  input  logic              ld_en,
  input  logic [15:0]       ld_sel,
  input  logic [31:0]       ld_base,
  input  logic [31:0]       ld_limit,
  input  logic              ld_rd,
  input  logic              ld_wr,
  input  logic              ld_ex,
  input  logic              ld_asz32,
  input  logic              ld_osz32,
  input  logic [31:0]       acc_off,
  input  logic [1:0]        acc_len,
  input  logic [1:0]        acc_type,
  output logic [15:0]       sel_q,
  output logic [31:0]       lin_addr,
  output logic              lim_fault,
  output logic              perm_fault,
  output logic              cur_asz32,
  output logic              cur_osz32
);
  logic      rst_sync_n;
  seg_desc_t ld_desc;
  seg_desc_t cache_q;

  assign ld_desc = '{base: ld_base, limit: ld_limit, rd: ld_rd, wr: ld_wr,
                     ex: ld_ex, asz32: ld_asz32, osz32: ld_osz32};

  seg_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  seg_sel_reg #(.SEL_W(SEL_W)) u_sel (
    .clk(clk), .rst_n(rst_sync_n), .ld_en(ld_en), .ld_sel(ld_sel), .sel_q(sel_q)
  );

  seg_cache_reg #(.SEL_W(SEL_W), .SHIFT(SHIFT)) u_cache (
    .clk(clk), .rst_n(rst_sync_n), .prot_mode(prot_mode), .ld_en(ld_en),
    .ld_sel(ld_sel), .ld_desc(ld_desc), .cache_q(cache_q)
  );

  seg_agu #(.NARROW(NARROW_W)) u_agu (
    .cache_q(cache_q), .acc_off(acc_off), .acc_len(acc_len), .acc_type(acc_type),
    .lin_addr(lin_addr), .lim_fault(lim_fault), .perm_fault(perm_fault)
  );

  assign cur_asz32 = cache_q.asz32;
  assign cur_osz32 = cache_q.osz32;
endmodule

// File: rtl/seg_unit_chk.sv
module seg_unit_chk
  import seg_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        prot_mode,
  input logic        ld_en,
  input logic [15:0] ld_sel,
  input seg_desc_t   ld_desc,
  input seg_desc_t   cache_q,
  input logic [15:0] sel_q,
  input logic [1:0]  acc_type,
  input logic        lim_fault,
  input logic        perm_fault
);
  localparam int unsigned PAD = ADDR_W - SEL_W - SHIFT;

  p_real_base_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_en && !prot_mode) |=> cache_q.base == {{PAD{1'b0}}, $past(ld_sel), {SHIFT{1'b0}}});

  p_real_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_en && !prot_mode) |=> (cache_q.limit == $past(cache_q.limit)) &&
      (cache_q.rd == $past(cache_q.rd)) && (cache_q.wr == $past(cache_q.wr)) &&
      (cache_q.ex == $past(cache_q.ex)) && (cache_q.asz32 == $past(cache_q.asz32)) &&
      (cache_q.osz32 == $past(cache_q.osz32)));

  p_prot_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_en && prot_mode) |=> cache_q == $past(ld_desc));

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_en |=> $stable(cache_q));

  p_narrow_fit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cache_q.limit == '1 && !cache_q.asz32) |-> !lim_fault);

  p_write_perm_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_type == 2'd1) |-> perm_fault == !cache_q.wr);

  p_sel_track_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ld_en |=> sel_q == $past(ld_sel));
endmodule

bind seg_unit seg_unit_chk u_chk (
  .clk(clk), .rst_n(rst_sync_n), .prot_mode(prot_mode), .ld_en(ld_en),
  .ld_sel(ld_sel), .ld_desc(ld_desc), .cache_q(cache_q), .sel_q(sel_q),
  .acc_type(acc_type), .lim_fault(lim_fault), .perm_fault(perm_fault)
);

// File: tb/seg_unit_test.sv
`timescale 1ns/1ps
module seg_unit_test;
  logic        clk, rst_n, prot_mode, ld_en;
  logic [15:0] ld_sel;
  logic [31:0] ld_base, ld_limit;
  logic        ld_rd, ld_wr, ld_ex, ld_asz32, ld_osz32;
  logic [31:0] acc_off;
  logic [1:0]  acc_len, acc_type;
  logic [15:0] sel_q;
  logic [31:0] lin_addr;
  logic        lim_fault, perm_fault, cur_asz32, cur_osz32;

  int checks = 0;
  int fails  = 0;

  // bench model of the cache, kept from the requirements
  logic [31:0] m_base, m_limit;
  logic        m_rd, m_wr, m_ex, m_a32, m_o32;
  logic [15:0] m_sel;

  seg_unit uut (
    .clk(clk), .rst_n(rst_n), .prot_mode(prot_mode), .ld_en(ld_en), .ld_sel(ld_sel),
    .ld_base(ld_base), .ld_limit(ld_limit), .ld_rd(ld_rd), .ld_wr(ld_wr), .ld_ex(ld_ex),
    .ld_asz32(ld_asz32), .ld_osz32(ld_osz32), .acc_off(acc_off), .acc_len(acc_len),
    .acc_type(acc_type), .sel_q(sel_q), .lin_addr(lin_addr), .lim_fault(lim_fault),
    .perm_fault(perm_fault), .cur_asz32(cur_asz32), .cur_osz32(cur_osz32)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic do_load(input logic pm, input logic [15:0] sel, input logic [31:0] b,
                         input logic [31:0] lim, input logic [2:0] rwx,
                         input logic a32, input logic o32);
    @(negedge clk);
    prot_mode = pm; ld_en = 1'b1; ld_sel = sel; ld_base = b; ld_limit = lim;
    {ld_rd, ld_wr, ld_ex} = rwx; ld_asz32 = a32; ld_osz32 = o32;
    @(negedge clk);
    ld_en = 1'b0;
    m_sel = sel;
    if (pm) begin
      m_base = b; m_limit = lim; {m_rd, m_wr, m_ex} = rwx; m_a32 = a32; m_o32 = o32;
    end else begin
      m_base = {12'h0, sel, 4'h0};
    end
  endtask

  task automatic set_mode(input logic pm);
    @(negedge clk);
    prot_mode = pm;
    @(negedge clk);
  endtask

  task automatic probe(input logic [31:0] off, input logic [1:0] len,
                       input logic [1:0] typ, input string tag);
    logic [31:0] eff, xl;
    logic [32:0] last;
    logic        xf, xp;
    acc_off = off; acc_len = len; acc_type = typ;
    #0.2;
    eff  = m_a32 ? off : {16'h0, off[15:0]};
    xl   = m_base + eff;
    last = {1'b0, eff} + {31'h0, len};
    xf   = last > {1'b0, m_limit};
    xp   = (typ == 2'd1) ? !m_wr : (typ == 2'd2) ? !m_ex : !m_rd;
    checks++;
    if (lin_addr !== xl || lim_fault !== xf || perm_fault !== xp ||
        sel_q !== m_sel || cur_asz32 !== m_a32 || cur_osz32 !== m_o32) begin
      fails++;
      $display("FAIL %s: off=%h len=%0d typ=%0d lin=%h exp %h lim=%b exp %b perm=%b exp %b sel=%h exp %h sz=%b%b exp %b%b",
               tag, off, len, typ, lin_addr, xl, lim_fault, xf, perm_fault, xp,
               sel_q, m_sel, cur_asz32, cur_osz32, m_a32, m_o32);
    end
  endtask

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL watchdog: run hung, got timeout exp completion");
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; prot_mode = 1'b0; ld_en = 1'b0; ld_sel = '0; ld_base = '0;
    ld_limit = '0; ld_rd = 0; ld_wr = 0; ld_ex = 0; ld_asz32 = 0; ld_osz32 = 0;
    acc_off = '0; acc_len = '0; acc_type = '0;
    m_base = 0; m_limit = 32'h0000_FFFF; m_rd = 1; m_wr = 1; m_ex = 1;
    m_a32 = 0; m_o32 = 0; m_sel = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state, R11 size flags
    probe(32'h0, 2'd0, 2'd0, "R1");
    probe(32'h0000_FFFF, 2'd0, 2'd1, "R1");
    probe(32'h0000_FFFF, 2'd1, 2'd2, "R1 R7");

    // R3 real-mode base from selector, R4 junk descriptor ignored
    for (int i = 0; i < 32; i++) begin
      do_load(1'b0, 16'(i * 16'h0F01), 32'hDEAD_0000 + 32'(i), 32'h0000_0010, 3'b000, 1'b1, 1'b1);
      probe(32'h0000_1234, 2'd3, 2'd1, "R3 R4");
      probe(32'h0000_FFFD, 2'd3, 2'd0, "R4 R7");
    end
    do_load(1'b0, 16'hF000, 32'h0, 32'h0, 3'b000, 1'b0, 1'b0);
    probe(32'h0, 2'd0, 2'd0, "R3");

    // R5 protected load of a 4 GiB segment; R2 address ignores selector
    do_load(1'b1, 16'h0008, 32'h0010_0000, 32'hFFFF_FFFF, 3'b111, 1'b1, 1'b1);
    probe(32'h0000_0000, 2'd0, 2'd0, "R5 R2");
    probe(32'h00AB_CDEF, 2'd3, 2'd1, "R5 R8");
    probe(32'hFFFF_FFFC, 2'd3, 2'd0, "R7");
    probe(32'hFFFF_FFFD, 2'd3, 2'd0, "R7 R2");

    // R6 mode switch keeps everything
    set_mode(1'b0);
    probe(32'h0020_0000, 2'd1, 2'd2, "R6");
    set_mode(1'b1);
    probe(32'h0020_0000, 2'd1, 2'd1, "R6 R10");
    set_mode(1'b0);

    // R4 real-mode reload keeps wide limit and 32-bit sizes
    do_load(1'b0, 16'hF000, 32'h1111_1111, 32'h0, 3'b000, 1'b0, 1'b0);
    probe(32'h0020_0000, 2'd3, 2'd1, "R4 R11");
    probe(32'h8000_0000, 2'd0, 2'd0, "R4 R8");

    // R7 limit boundary sweep, every length
    do_load(1'b1, 16'h0010, 32'h0004_0000, 32'h0000_1000, 3'b111, 1'b1, 1'b0);
    for (int off = 32'h0FF8; off <= 32'h1003; off++)
      for (int l = 0; l < 4; l++)
        probe(32'(off), 2'(l), 2'd0, "R7");

    // R8 16-bit address size masks offset
    do_load(1'b1, 16'h0018, 32'h0003_0000, 32'h0000_0100, 3'b111, 1'b0, 1'b1);
    probe(32'hABCD_0010, 2'd0, 2'd0, "R8");
    probe(32'hABCD_00FF, 2'd1, 2'd0, "R8 R7");
    probe(32'h0001_0100, 2'd0, 2'd0, "R8");

    // R2 wraparound past 2^32
    do_load(1'b1, 16'h0020, 32'hFFFF_FFF0, 32'hFFFF_FFFF, 3'b111, 1'b1, 1'b1);
    probe(32'h0000_0020, 2'd0, 2'd0, "R2");

    // R9 every permission set against every access kind
    for (int p = 0; p < 8; p++) begin
      do_load(1'b1, 16'(16'h0100 + p), 32'h0, 32'h0000_FFFF, 3'(p), 1'b0, 1'b0);
      for (int t = 0; t < 4; t++) probe(32'h40, 2'd0, 2'(t), "R9");
    end

    // R10 selector after mode switch
    set_mode(1'b0);
    probe(32'h10, 2'd0, 2'd0, "R10");

    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule